// File: doc/BRIEF.md
# SPI Master with Per-Frame Attribute Selection

This block is a serial peripheral controller. It holds a bank of eight attribute sets. Each set describes one frame shape: the number of bits, the idle level of the serial clock, which clock edge samples data, and whether the word goes out starting from its low end or its high end. Software fills the bank through a simple write port.

As bus master, every entry pushed into the transmit queue carries a data word and a 3-bit selector. The selector chooses which attribute set governs that frame. Frames of different shapes can therefore follow each other without any reconfiguration between them. When a frame starts, its attribute set is copied into a working register and stays fixed until the frame ends. Each completed frame returns the word received on the input line.

In slave mode the block follows an external clock and chip select. It always uses attribute set zero, whatever selector the queued entry carries.

Top module: `spi_frame_engine`

## Requirements
- R1: The bank holds eight attribute words. Each word is written as 7 bits: bits [3:0] hold the frame length minus one, bit 4 is the clock idle level, bit 5 is the phase select and bit 6 is the low-bit-first flag. After reset every word reads as frame length 8, idle level 0, phase 0, high bit first.
- R2: In master mode, the selector of an accepted queue entry chooses the attribute word for that frame. A frame of N bits produces exactly 2N serial clock transitions.
- R3: During a master frame the serial clock rests at the selected idle level when chip select falls, and it is back at that level when chip select rises.
- R4: With phase 0, the input is sampled on the first transition of each bit period and the output changes on the second. With phase 1, the output changes on the first transition and the input is sampled on the second.
- R5: With the low-bit-first flag set, bit 0 of the word is sent and received first. Otherwise bit N-1 is first.
- R6: In master mode, chip select (active low) stays low for the whole frame and is high between frames. The busy output is high whenever chip select is low.
- R7: A write to the bank while busy is high has no effect on any attribute word.
- R8: Once a frame has started, its attribute set stays fixed until the frame ends, even if the bank is written during the frame.
- R9: In slave mode, attribute word 0 governs the frame regardless of the selector of the queued entry.
- R10: At the end of a frame, the received word is presented with each bit at its own significance position and the bits at and above N cleared. A one-cycle valid pulse marks it.
- R11: A length field below 3 is treated as 3, so the shortest frame is 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| slaveMode | input | 1 | 1 selects slave operation, 0 master |
| cfgWe | input | 1 | Attribute bank write strobe |
| cfgIdx | input | 3 | Attribute word index |
| cfgData | input | 7 | Attribute word value |
| txValid | input | 1 | Queue entry present |
| txReady | output | 1 | Queue entry taken this cycle |
| txData | input | 16 | Word to send |
| txSel | input | 3 | Attribute selector of the entry |
| rxValid | output | 1 | Received word valid pulse |
| rxData | output | 16 | Received word |
| busy | output | 1 | Frame in progress |
| sck | output | 1 | Master serial clock |
| mosi | output | 1 | Master serial data out |
| miso | input | 1 | Master serial data in |
| csN | output | 1 | Master chip select, active low |
| slvSck | input | 1 | Slave serial clock in |
| slvCsN | input | 1 | Slave chip select in, active low |
| slvMosi | input | 1 | Slave serial data in |
| slvMiso | output | 1 | Slave serial data out |

## Verification
The hardest case to reach is a bank write that arrives in the middle of a frame. The write must leave both the running frame and the stored word untouched. The bench reaches it by injecting a write to the very word in use a few cycles after chip select falls. It then sends a second frame through that word and checks that the frame length, bit order and clock shape are still the old ones. Slave mode needs the bench to act as the master. It drives the clock slowly enough to survive the input synchronisers, and it queues an entry whose selector points at a word with a different shape.

// File: rtl/spi_attr_pkg.sv
package spi_attr_pkg;

  localparam int DATA_W = 16;
  localparam int LEN_W  = 4;
  localparam int MIN_LEN_M1 = 3;

  typedef struct packed {
    logic             lsbFirst;
    logic             cpha;
    logic             cpol;
    logic [LEN_W-1:0] lenM1;
  } attr_t;

  localparam int ATTR_W = $bits(attr_t);

  localparam attr_t ATTR_RESET = '{lsbFirst: 1'b0, cpha: 1'b0, cpol: 1'b0, lenM1: 4'd7};

  typedef struct packed {
    logic load;
    logic shiftOut;
    logic sampleIn;
    logic done;
  } strobe_t;

endpackage

// File: rtl/spi_attr_bank.sv
module spi_attr_bank
  import spi_attr_pkg::*;
#(
  parameter int NUM_SETS = 8,
  localparam int SEL_W = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busy,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrIdx,
  input  attr_t            wrAttr,
  input  logic [SEL_W-1:0] rdIdx,
  output attr_t            rdAttr
);

  attr_t [NUM_SETS-1:0] regs;

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regs[g] <= ATTR_RESET;
      end else if (wrEn && !busy && (wrIdx == SEL_W'(g))) begin
        regs[g] <= wrAttr;
      end
    end
  end

  assign rdAttr = regs[rdIdx];

  // R7: bank contents frozen while a frame runs
  a_r7_bank_frozen: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(regs));

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_attr_pkg::*;
#(
  parameter int HALF_DIV = 2,
  localparam int TMR_W = $clog2(HALF_DIV) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             slaveMode,
  input  logic             txValid,
  input  attr_t            rdAttr,
  input  logic             sckSync,
  input  logic             csSync,
  output logic             txReady,
  output strobe_t          stb,
  output logic             busy,
  output logic             csN,
  output logic             sck,
  output logic             modeSlave,
  output logic             lsbFirst,
  output logic [LEN_W-1:0] lenM1
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_TAIL, S_FIN} state_t;

  state_t           state;
  attr_t            attrCur;
  logic [TMR_W-1:0] timer;
  logic [LEN_W:0]   edgeCnt;
  logic             sckPhase;
  logic             sckPrev;
  logic             csPrev;

  logic startM, startS, tick, edgeEv, leading, lastEdge, abortS;
  logic [LEN_W-1:0] lenEff;

  assign lenEff   = (attrCur.lenM1 < LEN_W'(MIN_LEN_M1)) ? LEN_W'(MIN_LEN_M1) : attrCur.lenM1;
  assign startM   = (state == S_IDLE) && !slaveMode && txValid;
  assign startS   = (state == S_IDLE) && slaveMode && csPrev && !csSync;
  assign tick     = (timer == TMR_W'(HALF_DIV - 1));
  assign abortS   = (state == S_RUN) && modeSlave && csSync;
  assign edgeEv   = (state == S_RUN) && !abortS &&
                    (modeSlave ? (sckSync != sckPrev) : tick);
  assign leading  = !edgeCnt[0];
  assign lastEdge = (edgeCnt == {lenEff, 1'b1});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      attrCur   <= ATTR_RESET;
      timer     <= '0;
      edgeCnt   <= '0;
      sckPhase  <= 1'b0;
      modeSlave <= 1'b0;
      sckPrev   <= 1'b0;
      csPrev    <= 1'b1;
    end else begin
      sckPrev <= sckSync;
      csPrev  <= csSync;
      unique case (state)
        S_IDLE: begin
          if (startM || startS) begin
            state     <= S_RUN;
            attrCur   <= rdAttr;
            modeSlave <= startS;
            timer     <= '0;
            edgeCnt   <= '0;
            sckPhase  <= 1'b0;
          end
        end
        S_RUN: begin
          if (abortS) begin
            state <= S_IDLE;
          end else begin
            if (!modeSlave) timer <= tick ? '0 : timer + 1'b1;
            if (edgeEv) begin
              edgeCnt <= edgeCnt + 1'b1;
              if (!modeSlave) sckPhase <= !sckPhase;
              if (lastEdge) state <= modeSlave ? S_FIN : S_TAIL;
            end
          end
        end
        S_TAIL: begin
          timer <= tick ? '0 : timer + 1'b1;
          if (tick) state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign txReady      = startM || startS;
  assign stb.load     = startM || startS;
  assign stb.sampleIn = edgeEv && (attrCur.cpha ? !leading : leading);
  assign stb.shiftOut = edgeEv && (attrCur.cpha ? (leading && (edgeCnt != '0))
                                                : (!leading && !lastEdge));
  assign stb.done     = (state == S_FIN);
  assign busy         = (state != S_IDLE);
  assign csN          = !(!modeSlave && ((state == S_RUN) || (state == S_TAIL)));
  assign sck          = attrCur.cpol ^ sckPhase;
  assign lsbFirst     = attrCur.lsbFirst;
  assign lenM1        = lenEff;

  // R3: clock is back at its rest level whenever no frame runs
  a_r3_idle_phase: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> !sckPhase);

  // R2: never more transitions than the frame length allows
  a_r2_edge_limit: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN) |-> (edgeCnt <= {lenEff, 1'b1}));

  // R9: a slave frame never drives the master chip select
  a_r9_slave_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (modeSlave && busy) |-> csN);

  // R8: working attributes hold for the whole frame
  a_r8_attr_hold: assert property (@(posedge clk) disable iff (!rstN)
    ((state != S_IDLE) && $past(state != S_IDLE)) |-> $stable(attrCur));

endmodule

// File: rtl/spi_frame_dpath.sv
module spi_frame_dpath
  import spi_attr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] loadWord,
  input  logic              lsbFirst,
  input  logic [LEN_W-1:0]  lenM1,
  input  logic              serIn,
  output logic              serOut,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData
);

  logic [DATA_W-1:0] txBuf;
  logic [DATA_W-1:0] rxBuf;
  logic [LEN_W-1:0]  outPos;
  logic [LEN_W-1:0]  inPos;

  function automatic logic [LEN_W-1:0] bitIdx(input logic [LEN_W-1:0] pos,
                                              input logic [LEN_W-1:0] topIdx,
                                              input logic lowFirst);
    return lowFirst ? pos : (topIdx - pos);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf   <= '0;
      rxBuf   <= '0;
      outPos  <= '0;
      inPos   <= '0;
      rxValid <= 1'b0;
      rxData  <= '0;
    end else begin
      rxValid <= stb.done;
      if (stb.done) rxData <= rxBuf;
      if (stb.load) begin
        txBuf  <= loadWord;
        rxBuf  <= '0;
        outPos <= '0;
        inPos  <= '0;
      end else begin
        if (stb.shiftOut) outPos <= outPos + 1'b1;
        if (stb.sampleIn) begin
          rxBuf[bitIdx(inPos, lenM1, lsbFirst)] <= serIn;
          inPos <= inPos + 1'b1;
        end
      end
    end
  end

  assign serOut = txBuf[bitIdx(outPos, lenM1, lsbFirst)];

  // R10: the received word is flagged for exactly one cycle
  a_r10_rx_single: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_attr_pkg::*;
#(
  parameter int NUM_SETS = 8,
  parameter int HALF_DIV = 2,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W = $clog2(NUM_SETS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slaveMode,
  input  logic              cfgWe,
  input  logic [SEL_W-1:0]  cfgIdx,
  input  logic [ATTR_W-1:0] cfgData,
  input  logic              txValid,
  output logic              txReady,
  input  logic [DATA_W-1:0] txData,
  input  logic [SEL_W-1:0]  txSel,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              csN,
  input  logic              slvSck,
  input  logic              slvCsN,
  input  logic              slvMosi,
  output logic              slvMiso
);

  localparam int PIN_N = 3;

  attr_t            rdAttr;
  strobe_t          stb;
  logic             modeSlave, lsbFirst, serOut, serIn;
  logic [LEN_W-1:0] lenM1;
  logic [SEL_W-1:0] rdIdx;
  logic [PIN_N-1:0] pinRaw, pinSync;
  logic [DATA_W-1:0] loadWord;

  assign pinRaw = {slvMosi, slvCsN, slvSck};

  for (genvar p = 0; p < PIN_N; p++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= (p == 1) ? '1 : '0;
      else       chain <= {chain[SYNC_STAGES-2:0], pinRaw[p]};
    end
    assign pinSync[p] = chain[SYNC_STAGES-1];
  end

  assign rdIdx    = slaveMode ? '0 : txSel;
  assign loadWord = txValid ? txData : '0;
  assign serIn    = modeSlave ? pinSync[2] : miso;

  spi_attr_bank #(.NUM_SETS(NUM_SETS)) bank_i (
    .clk(clk), .rstN(rstN), .busy(busy),
    .wrEn(cfgWe), .wrIdx(cfgIdx), .wrAttr(attr_t'(cfgData)),
    .rdIdx(rdIdx), .rdAttr(rdAttr)
  );

  spi_frame_ctrl #(.HALF_DIV(HALF_DIV)) ctrl_i (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode), .txValid(txValid),
    .rdAttr(rdAttr), .sckSync(pinSync[0]), .csSync(pinSync[1]),
    .txReady(txReady), .stb(stb), .busy(busy), .csN(csN), .sck(sck),
    .modeSlave(modeSlave), .lsbFirst(lsbFirst), .lenM1(lenM1)
  );

  spi_frame_dpath dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .loadWord(loadWord),
    .lsbFirst(lsbFirst), .lenM1(lenM1), .serIn(serIn),
    .serOut(serOut), .rxValid(rxValid), .rxData(rxData)
  );

  assign mosi    = (busy && !modeSlave) ? serOut : 1'b0;
  assign slvMiso = (busy && modeSlave) ? serOut : 1'b0;

  // R6: chip select low implies busy
  a_r6_cs_busy: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> busy);

endmodule

// File: tb/spi_frame_engine_tb_top.sv
module spi_frame_engine_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slaveMode = 1'b0;
  logic cfgWe = 1'b0;
  logic [2:0] cfgIdx = '0;
  logic [6:0] cfgData = '0;
  logic txValid = 1'b0;
  logic txReady;
  logic [15:0] txData = '0;
  logic [2:0] txSel = '0;
  logic rxValid;
  logic [15:0] rxData;
  logic busy, sck, mosi, csN, slvMiso;
  logic miso = 1'b0;
  logic slvSck = 1'b0, slvCsN = 1'b1, slvMosi = 1'b0;

  int errors = 0;
  int checks = 0;

  always #4 clk = !clk;

  spi_frame_engine dut_i (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode), .cfgWe(cfgWe),
    .cfgIdx(cfgIdx), .cfgData(cfgData), .txValid(txValid), .txReady(txReady),
    .txData(txData), .txSel(txSel), .rxValid(rxValid), .rxData(rxData),
    .busy(busy), .sck(sck), .mosi(mosi), .miso(miso), .csN(csN),
    .slvSck(slvSck), .slvCsN(slvCsN), .slvMosi(slvMosi), .slvMiso(slvMiso)
  );

  // expectation state for the pin monitor
  bit monOn = 0;
  int expN = 8;
  bit expCpha = 0, expLsb = 0;
  logic [15:0] misoPat = '0;
  int monEdges = 0;
  logic [15:0] mosiCap = '0;
  logic startSck = 0, endSck = 0, busyAtStart = 0;
  logic prevCs = 1, prevSck = 0;
  bit gotRx = 0;
  logic [15:0] rxCap = '0;

  function automatic int ob(int k, int n, bit lsb);
    return lsb ? k : (n - 1 - k);
  endfunction

  function automatic logic [6:0] mk(int len, bit cpol, bit cpha, bit lsb);
    logic [3:0] f;
    f = 4'(len - 1);
    return {lsb, cpha, cpol, f};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (monOn) begin
      if (prevCs && !csN) begin
        monEdges = 0;
        mosiCap = '0;
        startSck = sck;
        busyAtStart = busy;
        if (!expCpha) miso = misoPat[ob(0, expN, expLsb)];
      end else if (!csN && (sck != prevSck)) begin
        int k;
        bit lead;
        lead = (monEdges % 2) == 0;
        k = monEdges / 2;
        if (expCpha ? !lead : lead) mosiCap[ob(k, expN, expLsb)] = mosi;
        if (expCpha && lead) miso = misoPat[ob(k, expN, expLsb)];
        if (!expCpha && !lead && (k + 1 < expN)) miso = misoPat[ob(k + 1, expN, expLsb)];
        monEdges++;
      end
      if (!prevCs && csN) endSck = sck;
    end
    prevCs = csN;
    prevSck = sck;
    if (rxValid) begin
      gotRx = 1;
      rxCap = rxData;
    end
  end

  task automatic cfgWrite(int idx, logic [6:0] val);
    @(negedge clk);
    cfgWe = 1; cfgIdx = 3'(idx); cfgData = val;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic waitRx(string req);
    int n = 0;
    while (!gotRx && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(req, 32'(gotRx), 1, "rxValid pulse seen");
  endtask

  task automatic masterFrame(string req, int sel, int n, bit cpol, bit cpha, bit lsb,
                             logic [15:0] tx, logic [15:0] pat,
                             bit doWrite, int wIdx, logic [6:0] wVal);
    logic [15:0] mask;
    mask = 16'((32'd1 << n) - 1);
    expN = n; expCpha = cpha; expLsb = lsb; misoPat = pat;
    monOn = 1; gotRx = 0;
    @(negedge clk);
    txValid = 1; txSel = 3'(sel); txData = tx;
    @(negedge clk);
    chk(req, 32'(busy), 1, "frame accepted");
    txValid = 0;
    if (doWrite) begin
      repeat (3) @(negedge clk);
      cfgWrite(wIdx, wVal);
    end
    waitRx(req);
    @(negedge clk);
    chk(req, 32'(monEdges), 32'(2 * n), "clock transitions");
    chk(req, 32'(mosiCap & mask), 32'(tx & mask), "serial out word");
    chk(req, 32'(rxCap), 32'(pat & mask), "received word");
    chk(req, 32'(startSck), 32'(cpol), "clock level at select fall");
    chk(req, 32'(endSck), 32'(cpol), "clock level at select rise");
    chk(req, 32'(busyAtStart), 1, "busy with select low");
    chk(req, {30'd0, csN, busy}, 32'b10, "idle after frame");
    monOn = 0;
  endtask

  task automatic t_reset();
    chk("R6", {27'd0, csN, busy, rxValid, sck, slvMiso}, 32'b10000, "reset outputs");
  endtask

  task automatic t_default();
    // R1 reset attributes: 8 bits, idle 0, phase 0, high bit first
    masterFrame("R1", 3, 8, 0, 0, 0, 16'h00A5, 16'h003C, 0, 0, '0);
  endtask

  task automatic t_modes();
    cfgWrite(1, mk(16, 1, 0, 1));
    cfgWrite(5, mk(5, 0, 1, 0));
    cfgWrite(6, mk(12, 1, 1, 1));
    cfgWrite(7, mk(9, 0, 0, 0));
    masterFrame("R2", 1, 16, 1, 0, 1, 16'hC3A1, 16'h5E72, 0, 0, '0);
    masterFrame("R4", 5, 5, 0, 1, 0, 16'hFF16, 16'h0019, 0, 0, '0);
    masterFrame("R5", 6, 12, 1, 1, 1, 16'h0B2D, 16'hA6C3, 0, 0, '0);
    masterFrame("R3", 7, 9, 0, 0, 0, 16'h0155, 16'h01AA, 0, 0, '0);
    // back-to-back shapes via selector only
    masterFrame("R2", 1, 16, 1, 0, 1, 16'h8001, 16'h7FFE, 0, 0, '0);
  endtask

  task automatic t_clamp();
    cfgWrite(4, 7'(mk(2, 0, 0, 1)));
    masterFrame("R11", 4, 4, 0, 0, 1, 16'hFFF9, 16'hFFF6, 0, 0, '0);
  endtask

  task automatic t_busy_write();
    cfgWrite(2, mk(12, 1, 1, 1));
    // R8: write to the word in use during the frame
    masterFrame("R8", 2, 12, 1, 1, 1, 16'h0A5C, 16'h0F0F, 1, 2, mk(4, 0, 0, 0));
    // R7: word 2 must still describe the 12-bit shape
    masterFrame("R7", 2, 12, 1, 1, 1, 16'h0963, 16'h0C71, 0, 0, '0);
  endtask

  task automatic t_slave();
    int n = 10;
    int half = 10;
    logic [15:0] tx = 16'h02D9;
    logic [15:0] pat = 16'h0166;
    logic [15:0] misoCap = '0;
    logic [15:0] mask;
    bit cpol = 1, cpha = 1, lsb = 1;
    mask = 16'((32'd1 << n) - 1);
    cfgWrite(0, mk(n, cpol, cpha, lsb));
    cfgWrite(4, mk(4, 0, 0, 0));
    @(negedge clk);
    slaveMode = 1; slvSck = cpol; gotRx = 0;
    txValid = 1; txSel = 3'd4; txData = tx;
    repeat (4) @(negedge clk);
    slvCsN = 0;
    for (int w = 0; w < 8 && !busy; w++) @(negedge clk);
    chk("R9", 32'(busy), 1, "slave frame started");
    txValid = 0;
    for (int e = 0; e < 2 * n; e++) begin
      bit lead = (e % 2) == 0;
      int k = e / 2;
      repeat (half / 2) @(negedge clk);
      if (cpha ? !lead : lead) slvMosi = pat[ob(k, n, lsb)];
      repeat (half / 2) @(negedge clk);
      if (cpha ? !lead : lead) misoCap[ob(k, n, lsb)] = slvMiso;
      slvSck = !slvSck;
    end
    waitRx("R9");
    chk("R9", 32'(rxCap), 32'(pat & mask), "slave received word");
    chk("R9", 32'(misoCap), 32'(tx & mask), "slave sent word");
    chk("R9", 32'(csN), 1, "master select quiet in slave mode");
    repeat (half) @(negedge clk);
    slvCsN = 1;
    repeat (half) @(negedge clk);
    chk("R9", 32'(busy), 0, "slave idle after frame");
    slaveMode = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    repeat (2) @(negedge clk);
    t_default();
    t_modes();
    t_clamp();
    t_busy_write();
    t_slave();
    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule